// File: doc/BRIEF.md
# Adaptive Two-Dimensional Comb Luma/Chroma Separator

This block splits a stream of composite video samples into a luma part and a chroma part. It does this per sample by picking one of three luma estimates. The first is a notch along the line that removes the subcarrier. The second is a three-line vertical average that cancels chroma, whose phase inverts from line to line. The third is the rounded mean of the two. Local edge detectors make the choice. If the picture changes sharply from one line to the next, vertical averaging would smear the change, so the notch along the line is used. If the picture changes sharply along the line but not between lines, the vertical average is used. Otherwise the blend is used. Chroma is the centre composite sample minus the chosen luma, so the two outputs always add back to the input.

Samples are 10 bits at eight samples per subcarrier cycle. A valid strobe qualifies each sample and a line-start strobe marks the first sample of a line. The block keeps two line delays of programmable length, so the output refers to the previous line's sample four positions back. A separate `mode` code reports which estimate was used.

Top module: `ycsep_comb2d`

## Requirements
- R1: `out_valid` is high exactly two clock cycles after a cycle with `in_valid` high. Samples pass through in order, and no output appears without an input.
- R2: When a line-to-line edge is present, `y_out` is the notch result `(m[-4] + 2m[-2] + 2m[0] + 2m[+2] + m[+4] + 4) >> 3`. Here m is the previous line, indexed in samples around the centre. `sel_mode` reads 2'b01 in this case.
- R3: When only an along-line edge is present, `y_out` is `(t + 2m[0] + b + 2) >> 2`, where t is the line two back and b is the current line, both at the centre position. `sel_mode` reads 2'b10 in this case.
- R4: When neither edge is present, `y_out` is `(notch + vertical + 1) >> 1` and `sel_mode` reads 2'b11.
- R5: When both edges are present at once, the line-to-line rule wins and the notch result (mode 2'b01) is used.
- R6: A line-to-line edge means `|m[0]-t|` or `|m[0]-b|` is strictly greater than `vert_thr`. An along-line edge means `|m[-4]-m[+4]|` (one subcarrier period apart) is strictly greater than `horiz_thr`. A difference equal to a threshold is not an edge.
- R7: `c_out` is the two's-complement value `m[0] - y_out`, so `y_out + c_out` equals the composite sample taken one line and four samples before the newest input.
- R8: The line delays are `line_len` samples long. The in-line position returns to zero on every valid sample with `in_sol` high, and also after position `line_len-1`. Changing `line_len` or starting a line early keeps the delays aligned to the position.
- R9: While `rst_n` is low at a clock edge, `out_valid`, `y_out`, `c_out` and `sel_mode` clear to zero at that edge.
- R10: Cycles with `in_valid` low advance nothing. `y_out`, `c_out` and `sel_mode` hold their last values while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Composite sample valid |
| in_sol | input | 1 | First sample of a line (qualified by in_valid) |
| in_sample | input | W (10) | Composite sample, unsigned |
| line_len | input | $clog2(MAX_LINE+1) (11) | Samples per line |
| vert_thr | input | W (10) | Line-to-line edge threshold |
| horiz_thr | input | W (10) | Along-line edge threshold |
| out_valid | output | 1 | Output sample valid |
| y_out | output | W (10) | Separated luma |
| c_out | output | W+1 (11) | Separated chroma, two's complement |
| sel_mode | output | 2 | 01 notch, 10 vertical, 11 blend, 00 after reset |

## Verification
The selector is driven with six kinds of picture. A flat field must give the blend with zero chroma. A subcarrier whose sign flips every line trips only the line-to-line detector and must be removed by the notch. A ramp repeated on every line trips only the along-line detector and selects the vertical average. The same ramp with an offset on alternate lines trips both detectors and shows the priority. Line pairs and ramps set exactly on each threshold, and then one code above it, show where each comparison turns. Line-length changes, early line starts and gaps in the valid strobe show that the line delays stay aligned to the in-line position.

// File: rtl/ycsep_pkg.sv
// Shared types for the comb luma/chroma separator.
package ycsep_pkg;
    // Luma estimate selected for one output sample
    typedef enum logic [1:0] {
        SEL_NONE  = 2'b00,
        SEL_HORIZ = 2'b01,
        SEL_VERT  = 2'b10,
        SEL_BLEND = 2'b11
    } sel_e;
endpackage

// File: rtl/ycsep_linebuf.sv
// Two cascaded line delays addressed by in-line position.
// Assumes line_len is between 1 and DEPTH. Storage is not reset;
// the first two lines after reset return stale data.
module ycsep_linebuf #(
    parameter int W     = 10,
    parameter int DEPTH = 1024,
    localparam int AW    = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             sol,
    input  logic [LEN_W-1:0] line_len,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dly1,
    output logic [W-1:0]     dly2
);
    logic [W-1:0]     mem_a [DEPTH];
    logic [W-1:0]     mem_b [DEPTH];
    logic [AW-1:0]    pos_q;
    logic [AW-1:0]    pos_now;
    logic [LEN_W-1:0] pos_inc;
    logic             pos_wrap;

    // Position of the current sample and its successor
    always_comb begin
        pos_now  = sol ? '0 : pos_q;
        pos_inc  = LEN_W'(pos_now) + LEN_W'(1);
        pos_wrap = (pos_inc >= line_len);
    end

    // In-line position counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (wr_en)
            pos_q <= pos_wrap ? '0 : pos_inc[AW-1:0];
    end

    // Cascade the new sample through both line stores
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_a[pos_now] <= din;
            mem_b[pos_now] <= mem_a[pos_now];
        end
    end

    assign dly1 = mem_a[pos_now];
    assign dly2 = mem_b[pos_now];
endmodule

// File: rtl/ycsep_taps.sv
// Sample shift chain exposing NTAP taps spaced STRIDE samples apart.
// Tap 0 is the newest sample. The chain moves only when shift is high.
module ycsep_taps #(
    parameter int W      = 10,
    parameter int NTAP   = 5,
    parameter int STRIDE = 2,
    localparam int LEN   = (NTAP - 1) * STRIDE + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift,
    input  logic [W-1:0]              din,
    output logic [NTAP-1:0][W-1:0]    tap
);
    logic [LEN-1:0][W-1:0] sr;

    // Shift a new sample in on every qualified cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= '0;
        else if (shift) begin
            sr[0] <= din;
            for (int i = 1; i < LEN; i++)
                sr[i] <= sr[i-1];
        end
    end

    // Bring out every STRIDE-th stage
    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        assign tap[k] = sr[k*STRIDE];
    end
endmodule

// File: rtl/ycsep_delay.sv
// Fixed sample delay of D qualified samples; output is the oldest stage.
module ycsep_delay #(
    parameter int W = 10,
    parameter int D = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [D-1:0][W-1:0] r;

    // Move samples one stage per qualified cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            r <= '0;
        else if (shift) begin
            r[0] <= din;
            for (int i = 1; i < D; i++)
                r[i] <= r[i-1];
        end
    end

    assign dout = r[D-1];
endmodule

// File: rtl/ycsep_decide.sv
// Edge detection, the three luma estimates and the selection between them.
// Purely combinational. mid holds five previous-line taps a quarter
// subcarrier period apart, with the centre in slot 2; top and bot are
// the lines above and below at the centre position.
module ycsep_decide
    import ycsep_pkg::*;
#(
    parameter int W = 10
) (
    input  logic [W-1:0]        top,
    input  logic [4:0][W-1:0]   mid,
    input  logic [W-1:0]        bot,
    input  logic [W-1:0]        vthr,
    input  logic [W-1:0]        hthr,
    output logic [W-1:0]        center,
    output logic [W-1:0]        y,
    output sel_e                mode
);
    localparam int SW = W + 4;

    logic [SW-1:0] hsum, vsum;
    logic [W:0]    bsum;
    logic [W-1:0]  y_h, y_v, y_b;
    logic          v_edge, h_edge;

    function automatic logic [W-1:0] adiff(input logic [W-1:0] a, input logic [W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    // Notch, vertical and blended estimates with rounding
    always_comb begin
        hsum = SW'(mid[0]) + (SW'(mid[1]) << 1) + (SW'(mid[2]) << 1)
             + (SW'(mid[3]) << 1) + SW'(mid[4]) + SW'(4);
        vsum = SW'(top) + (SW'(mid[2]) << 1) + SW'(bot) + SW'(2);
        y_h  = W'(hsum >> 3);
        y_v  = W'(vsum >> 2);
        bsum = (W+1)'(y_h) + (W+1)'(y_v) + (W+1)'(1);
        y_b  = W'(bsum >> 1);
    end

    // Edge detectors and priority selection (line-to-line edge first)
    always_comb begin
        v_edge = (adiff(mid[2], top) > vthr) || (adiff(mid[2], bot) > vthr);
        h_edge = adiff(mid[0], mid[4]) > hthr;
        if (v_edge) begin
            mode = SEL_HORIZ;
            y    = y_h;
        end else if (h_edge) begin
            mode = SEL_VERT;
            y    = y_v;
        end else begin
            mode = SEL_BLEND;
            y    = y_b;
        end
    end

    assign center = mid[2];
endmodule

// File: rtl/ycsep_comb2d.sv
// Adaptive comb separator top level. Assumes SPS is a multiple of 4 so that
// quarter-period taps fall on whole samples. Latency: two clock cycles from
// a valid input to its output; the output refers to the previous line,
// SPS/2 samples behind the newest input.
module ycsep_comb2d
    import ycsep_pkg::*;
#(
    parameter int W        = 10,
    parameter int MAX_LINE = 1024,
    parameter int SPS      = 8,
    localparam int LEN_W   = $clog2(MAX_LINE + 1),
    localparam int CTR     = SPS / 2,
    localparam int QS      = SPS / 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic [W-1:0]     in_sample,
    input  logic [LEN_W-1:0] line_len,
    input  logic [W-1:0]     vert_thr,
    input  logic [W-1:0]     horiz_thr,
    output logic             out_valid,
    output logic [W-1:0]     y_out,
    output logic [W:0]       c_out,
    output logic [1:0]       sel_mode
);
    logic [W-1:0]       line1, line2;
    logic [4:0][W-1:0]  mid_t;
    logic [W-1:0]       top_c, bot_c;
    logic [W-1:0]       ctr, y_sel;
    sel_e               mode_sel;
    logic               s_v;

    ycsep_linebuf #(.W(W), .DEPTH(MAX_LINE)) u_lbuf (
        .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .sol(in_sol),
        .line_len(line_len), .din(in_sample), .dly1(line1), .dly2(line2)
    );

    ycsep_taps #(.W(W), .NTAP(5), .STRIDE(QS)) u_mid (
        .clk(clk), .rst_n(rst_n), .shift(in_valid), .din(line1), .tap(mid_t)
    );

    ycsep_delay #(.W(W), .D(CTR + 1)) u_top (
        .clk(clk), .rst_n(rst_n), .shift(in_valid), .din(line2), .dout(top_c)
    );

    ycsep_delay #(.W(W), .D(CTR + 1)) u_bot (
        .clk(clk), .rst_n(rst_n), .shift(in_valid), .din(in_sample), .dout(bot_c)
    );

    ycsep_decide #(.W(W)) u_dec (
        .top(top_c), .mid(mid_t), .bot(bot_c), .vthr(vert_thr), .hthr(horiz_thr),
        .center(ctr), .y(y_sel), .mode(mode_sel)
    );

    // Stage flag: tap registers hold a freshly shifted window
    always_ff @(posedge clk) begin
        if (!rst_n)
            s_v <= 1'b0;
        else
            s_v <= in_valid;
    end

    // Output registers; hold while no new window is present
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            y_out     <= '0;
            c_out     <= '0;
            sel_mode  <= SEL_NONE;
        end else begin
            out_valid <= s_v;
            if (s_v) begin
                y_out    <= y_sel;
                c_out    <= {1'b0, ctr} - {1'b0, y_sel};
                sel_mode <= mode_sel;
            end
        end
    end
endmodule

// File: rtl/ycsep_chk.sv
// Property checker for the comb separator, attached by bind below.
module ycsep_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         out_valid,
    input logic [W-1:0] y_out,
    input logic [W:0]   c_out,
    input logic [1:0]   sel_mode
);
    logic signed [W+1:0] recon;
    assign recon = $signed({2'b00, y_out}) + $signed({c_out[W], c_out});

    // R1
    out_has_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R1
    input_gives_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 2) && $past(rst_n, 2) && $past(rst_n, 1)) |-> out_valid);

    // R4
    mode_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (sel_mode != 2'b00));

    // R7
    recon_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (recon >= 0 && recon <= (2**W) - 1));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && sel_mode == 2'b00 && y_out == '0 && c_out == '0));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(rst_n)) |-> ($stable(y_out) && $stable(c_out) && $stable(sel_mode)));
endmodule

bind ycsep_comb2d ycsep_chk #(.W(W)) u_chk (.*);

// File: tb/ycsep_comb2d_test.sv
`timescale 1ns/1ps
module ycsep_comb2d_test;
    localparam int W  = 10;
    localparam int ML = 1024;
    localparam int LW = 11;
    localparam int VT = 50;
    localparam int HT = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sol = 1'b0;
    logic [W-1:0]  in_sample = '0;
    logic [LW-1:0] line_len = LW'(16);
    logic [W-1:0]  vert_thr = W'(VT);
    logic [W-1:0]  horiz_thr = W'(HT);
    logic          out_valid;
    logic [W-1:0]  y_out;
    logic [W:0]    c_out;
    logic [1:0]    sel_mode;

    ycsep_comb2d uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .in_sample(in_sample), .line_len(line_len), .vert_thr(vert_thr),
        .horiz_thr(horiz_thr), .out_valid(out_valid), .y_out(y_out),
        .c_out(c_out), .sel_mode(sel_mode)
    );

    always #4 clk = ~clk;

    int    tests = 0;
    int    fails = 0;
    string phase = "R9";
    bit    checking = 0;
    bit    done = 0;

    // Behavioural reference state
    int prev1 [ML];
    int prev2 [ML];
    int pos_m = 0;
    int lines_m = 0;
    int mq[$];
    int tq[$];
    int bq[$];
    bit s1_v = 0, s2_v = 0, s1_ok = 0, s2_ok = 0;
    int s1_y = 0, s2_y = 0, s1_c = 0, s2_c = 0, s1_m = 0, s2_m = 0;
    int held_y = 0;
    bit armed = 0;

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    // Reference model: advances on each qualified input sample
    always @(posedge clk) begin : model
        int p, mid, top, yh, yv, yb, ey, em;
        bit ve, he;
        if (!rst_n) begin
            s1_v <= 0; s2_v <= 0; pos_m = 0;
        end else begin
            s2_v <= s1_v; s2_ok <= s1_ok; s2_y <= s1_y; s2_c <= s1_c; s2_m <= s1_m;
            s1_v <= in_valid;
            if (in_valid) begin
                p = in_sol ? 0 : pos_m;
                if (in_sol) lines_m++;
                mid = prev1[p];
                top = prev2[p];
                prev2[p] = prev1[p];
                prev1[p] = int'(in_sample);
                mq.push_front(mid); if (mq.size() > 9) void'(mq.pop_back());
                tq.push_front(top); if (tq.size() > 5) void'(tq.pop_back());
                bq.push_front(int'(in_sample)); if (bq.size() > 5) void'(bq.pop_back());
                pos_m = (p + 1 >= int'(line_len)) ? 0 : p + 1;
                if (mq.size() == 9) begin
                    yh = (mq[0] + 2*mq[2] + 2*mq[4] + 2*mq[6] + mq[8] + 4) / 8;
                    yv = (tq[4] + 2*mq[4] + bq[4] + 2) / 4;
                    yb = (yh + yv + 1) / 2;
                    ve = (iabs(mq[4] - tq[4]) > VT) || (iabs(mq[4] - bq[4]) > VT);
                    he = iabs(mq[0] - mq[8]) > HT;
                    if (ve) begin em = 1; ey = yh; end
                    else if (he) begin em = 2; ey = yv; end
                    else begin em = 3; ey = yb; end
                    s1_y <= ey; s1_c <= mq[4] - ey; s1_m <= em;
                    s1_ok <= (lines_m >= 4);
                end else
                    s1_ok <= 0;
            end
        end
    end

    // Compare the design against the model away from the active edge
    always @(negedge clk) begin
        string tag;
        if (rst_n && checking) begin
            tests++;
            if (out_valid !== s2_v) begin
                fails++;
                $display("FAIL R1 (%s) out_valid=%0b expected=%0b", phase, out_valid, s2_v);
            end
            if (s2_v && s2_ok) begin
                tag = (s2_m == 1) ? "R2" : (s2_m == 2) ? "R3" : "R4";
                tests++;
                if (int'(y_out) != s2_y || int'(sel_mode) != s2_m) begin
                    fails++;
                    $display("FAIL %s (%s) y=%0d mode=%0d expected y=%0d mode=%0d",
                             tag, phase, y_out, sel_mode, s2_y, s2_m);
                end
                tests++;
                if (int'($signed(c_out)) != s2_c) begin
                    fails++;
                    $display("FAIL R7 (%s) c=%0d expected=%0d", phase, $signed(c_out), s2_c);
                end
                held_y = s2_y;
                armed = 1;
            end else if (s2_v) begin
                armed = 0;
            end else if (armed) begin
                tests++;
                if (int'(y_out) != held_y) begin
                    fails++;
                    $display("FAIL R10 (%s) held y=%0d expected=%0d", phase, y_out, held_y);
                end
            end
        end
    end

    function automatic int chroma(int p);
        case (p % 8)
            0: return 0;    1: return 70;   2: return 100;  3: return 70;
            4: return 0;    5: return -70;  6: return -100; default: return -70;
        endcase
    endfunction

    function automatic int pat(int kind, int ln, int p);
        case (kind)
            0: return 300;
            1: return 400 + ((ln % 2 == 1) ? -chroma(p) : chroma(p));
            2: return 100 + 40*p;
            3: return 100 + 40*p + ((ln % 2 == 1) ? 200 : 0);
            4: return (ln % 2 == 1) ? 500 + VT : 500;
            5: return (ln % 2 == 1) ? 501 + VT : 500;
            6: return 200 + (HT/8)*p;
            default: return 200 + (HT/8 + 1)*p;
        endcase
    endfunction

    int ln = 0;

    task automatic drive(int x, bit sol);
        if ($urandom_range(0, 3) == 0) begin
            @(negedge clk); in_valid = 0; in_sol = 0;
        end
        @(negedge clk); in_valid = 1; in_sol = sol; in_sample = W'(x);
    endtask

    task automatic send_lines(int kind, int count, int len);
        for (int l = 0; l < count; l++) begin
            for (int p = 0; p < len; p++) drive(pat(kind, ln, p), p == 0);
            ln++;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); in_valid = 0; in_sol = 0;
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    initial begin
        for (int i = 0; i < ML; i++) begin prev1[i] = 0; prev2[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9: outputs cleared by reset
        tests++;
        if (out_valid !== 1'b0 || y_out !== '0 || c_out !== '0 || sel_mode !== 2'b00) begin
            fails++;
            $display("FAIL R9 v=%0b y=%0d c=%0d mode=%0d expected all zero",
                     out_valid, y_out, c_out, sel_mode);
        end
        checking = 1;
        phase = "R4 flat";       send_lines(0, 6, 16);
        phase = "R2 chroma";     send_lines(1, 5, 16);
        phase = "R3 ramp";       send_lines(2, 5, 16);
        phase = "R5 both edges"; send_lines(3, 5, 16);
        phase = "R6 vert eq";    send_lines(4, 5, 16);
        phase = "R6 vert gt";    send_lines(5, 4, 16);
        phase = "R6 horiz eq";   send_lines(6, 5, 16);
        phase = "R6 horiz gt";   send_lines(7, 4, 16);
        phase = "R10 idle";      idle(6); send_lines(0, 3, 16);
        phase = "R8 len 12";     @(negedge clk); in_valid = 0; line_len = LW'(12);
        send_lines(2, 5, 12);
        phase = "R8 early sol";  line_len = LW'(16);
        send_lines(1, 6, 10);
        send_lines(0, 4, 16);
        idle(5);
        summary();
    end
endmodule